// File: doc/BRIEF.md
# Rename History Buffer with Rollback

This block keeps an ordered log of register renames for one thread. Each time the rename stage gives a destination register a fresh physical register, it inserts one entry at the young end of the log. The entry holds the instruction sequence number, the architectural register, the newly allocated physical register and the physical register that the new one displaced. An instruction with several destinations inserts one entry per destination, and consecutive entries then share a sequence number.

Two walks drain the log, one entry per cycle. A squash walk starts from the young end. It removes every entry younger than a given sequence number, writes the displaced physical register back into the external map table, and hands the newly allocated register back to the external free list. A commit walk starts from the old end. It removes every entry at or older than a given sequence number and returns only the displaced register to the free list. A flush is a squash with no age limit. The log is a circular array. A full flag tells the rename stage to stall, and a busy flag covers each walk from start to finish.

Top module: `rename_hist_buf`

## Requirements
- R1: After reset, empty=1, full=0, busy=0, mapWrEn=0 and freeEn=0.
- R2: An insert is taken on a clock edge when insValid=1, full=0, no squash walk is running, and neither sqValid nor flushValid is high in that cycle. Each insert adds one entry at the young end. full=1 exactly when DEPTH entries are held, and an insert while full is ignored.
- R3: When a squash request with target S is taken, each following cycle removes the youngest entry if its sequence number is younger than S. In that cycle mapWrEn=1, mapWrArch is the entry's architectural register, mapWrPhys is its displaced register, freeEn=1 and freePhys is its new register.
- R4: A squash request on an empty log removes nothing and produces no map or free-list write.
- R5: A flush request removes every entry, youngest first, with the same port activity as R3.
- R6: When a commit request with target C is taken, each following cycle removes the oldest entry if its sequence number is not younger than C. In that cycle freeEn=1, freePhys is the entry's displaced register, and mapWrEn=0.
- R7: A commit on an empty log, or with C older than the oldest entry, removes nothing.
- R8: A commit request is ignored when sqValid or flushValid is high in the same cycle, or when a walk is running. A squash or flush raised during a commit walk cancels the commit removal in that cycle and starts a squash walk.
- R9: Sequence a is younger than b when (a-b) modulo 2^SEQ_W is nonzero and below 2^(SEQ_W-1), so order holds across counter wraparound.
- R10: When flushValid and sqValid are high together, the flush wins and every entry is removed.
- R11: busy goes high in the cycle after a walk request is taken. It stays high through every removal cycle plus one final cycle with no removal, then drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| insValid | input | 1 | Insert request |
| insSeq | input | SEQ_W | Sequence number of inserted entry |
| insArch | input | ARCH_W | Architectural register of inserted entry |
| insNew | input | PHYS_W | Newly allocated physical register |
| insPrev | input | PHYS_W | Displaced physical register |
| sqValid | input | 1 | Squash request |
| sqSeq | input | SEQ_W | Squash target sequence number |
| flushValid | input | 1 | Full flush request |
| cmValid | input | 1 | Commit request |
| cmSeq | input | SEQ_W | Commit target sequence number |
| full | output | 1 | All entries in use |
| empty | output | 1 | No entry held |
| busy | output | 1 | A walk is in progress |
| mapWrEn | output | 1 | Map restore write strobe |
| mapWrArch | output | ARCH_W | Architectural register to restore |
| mapWrPhys | output | PHYS_W | Physical register written back into the map |
| freeEn | output | 1 | Free-list return strobe |
| freePhys | output | PHYS_W | Physical register returned |

## Verification
The bench uses the defaults DEPTH=8, SEQ_W=8, ARCH_W=5 and PHYS_W=6. With eight entries the log can be filled and overflowed in a handful of inserts. The 8-bit sequence counter starts at 240, so both walks' age comparisons cross the wrap from 255 to 0 early in the run. Repeated sequence numbers model multi-destination instructions, and squash and commit targets are drawn around the live window, so walks of length zero, partial and complete all occur.

// File: rtl/rhb_pkg.sv
package rhb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SQUASH = 2'd1,
    ST_COMMIT = 2'd2
  } walkState_t;

  typedef struct packed {
    logic pushEn;
    logic popYoung;
    logic popOld;
  } rhbStrobe_t;
endpackage

// File: rtl/rhb_store.sv
module rhb_store
  import rhb_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int SEQ_W  = 8,
  parameter int ARCH_W = 5,
  parameter int PHYS_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  rhbStrobe_t        strobe,
  input  logic [SEQ_W-1:0]  insSeq,
  input  logic [ARCH_W-1:0] insArch,
  input  logic [PHYS_W-1:0] insNew,
  input  logic [PHYS_W-1:0] insPrev,
  output logic [SEQ_W-1:0]  youngSeq,
  output logic [SEQ_W-1:0]  oldSeq,
  output logic              empty,
  output logic              full,
  output logic              mapWrEn,
  output logic [ARCH_W-1:0] mapWrArch,
  output logic [PHYS_W-1:0] mapWrPhys,
  output logic              freeEn,
  output logic [PHYS_W-1:0] freePhys
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W:0] FULL_CNT = (PTR_W+1)'(DEPTH);

  logic [SEQ_W-1:0]  seqMem  [DEPTH];
  logic [ARCH_W-1:0] archMem [DEPTH];
  logic [PHYS_W-1:0] newMem  [DEPTH];
  logic [PHYS_W-1:0] prevMem [DEPTH];

  logic [PTR_W:0]   headPtr, tailPtr, occCount;
  logic [PTR_W:0]   tailLast;
  logic [PTR_W-1:0] youngIdx, oldIdx, wrIdx;

  assign occCount = tailPtr - headPtr;
  assign empty    = (occCount == '0);
  assign full     = (occCount == FULL_CNT);
  assign tailLast = tailPtr - 1'b1;
  assign youngIdx = tailLast[PTR_W-1:0];
  assign oldIdx   = headPtr[PTR_W-1:0];
  assign wrIdx    = tailPtr[PTR_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headPtr <= '0;
      tailPtr <= '0;
    end else begin
      if (strobe.pushEn)        tailPtr <= tailPtr + 1'b1;
      else if (strobe.popYoung) tailPtr <= tailPtr - 1'b1;
      if (strobe.popOld)        headPtr <= headPtr + 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : gEntry
    always_ff @(posedge clk) begin
      if (strobe.pushEn && (wrIdx == PTR_W'(g))) begin
        seqMem[g]  <= insSeq;
        archMem[g] <= insArch;
        newMem[g]  <= insNew;
        prevMem[g] <= insPrev;
      end
    end
  end

  assign youngSeq  = seqMem[youngIdx];
  assign oldSeq    = seqMem[oldIdx];
  assign mapWrEn   = strobe.popYoung;
  assign mapWrArch = archMem[youngIdx];
  assign mapWrPhys = prevMem[youngIdx];
  assign freeEn    = strobe.popYoung | strobe.popOld;
  assign freePhys  = strobe.popYoung ? newMem[youngIdx] : prevMem[oldIdx];

  assert_no_push_full_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pushEn |-> !full);
  assert_no_pop_empty_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.popYoung || strobe.popOld) |-> !empty);
  assert_one_direction_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.popYoung, strobe.popOld}));
  assert_occupancy_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    occCount <= FULL_CNT);
endmodule

// File: rtl/rhb_ctrl.sv
module rhb_ctrl
  import rhb_pkg::*;
#(
  parameter int SEQ_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             insValid,
  input  logic             sqValid,
  input  logic [SEQ_W-1:0] sqSeq,
  input  logic             flushValid,
  input  logic             cmValid,
  input  logic [SEQ_W-1:0] cmSeq,
  input  logic [SEQ_W-1:0] youngSeq,
  input  logic [SEQ_W-1:0] oldSeq,
  input  logic             empty,
  input  logic             full,
  output rhbStrobe_t       strobe,
  output logic             busy
);
  walkState_t       state, nxtState;
  logic [SEQ_W-1:0] tgtSeq, nxtTgt;
  logic             flushAll, nxtAll;
  logic             canYoung, canOld;

  function automatic logic isYounger(input logic [SEQ_W-1:0] a, input logic [SEQ_W-1:0] b);
    logic [SEQ_W-1:0] diff;
    diff = a - b;
    return (diff != '0) && !diff[SEQ_W-1];
  endfunction

  assign canYoung = !empty && (flushAll || isYounger(youngSeq, tgtSeq));
  assign canOld   = !empty && !isYounger(oldSeq, tgtSeq);
  assign busy     = (state != ST_IDLE);

  always_comb begin
    nxtState = state;
    nxtTgt   = tgtSeq;
    nxtAll   = flushAll;
    strobe   = '0;
    strobe.pushEn = insValid && !full && (state != ST_SQUASH) && !sqValid && !flushValid;
    case (state)
      ST_SQUASH: begin
        if (canYoung) strobe.popYoung = 1'b1;
        else          nxtState = ST_IDLE;
      end
      default: begin
        if (flushValid) begin
          nxtState = ST_SQUASH;
          nxtAll   = 1'b1;
        end else if (sqValid) begin
          nxtState = ST_SQUASH;
          nxtTgt   = sqSeq;
          nxtAll   = 1'b0;
        end else if (state == ST_COMMIT) begin
          if (canOld) strobe.popOld = 1'b1;
          else        nxtState = ST_IDLE;
        end else if (cmValid) begin
          nxtState = ST_COMMIT;
          nxtTgt   = cmSeq;
          nxtAll   = 1'b0;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      tgtSeq   <= '0;
      flushAll <= 1'b0;
    end else begin
      state    <= nxtState;
      tgtSeq   <= nxtTgt;
      flushAll <= nxtAll;
    end
  end

  assert_commit_yields_R8: assert property (@(posedge clk) disable iff (!rstN)
    (sqValid || flushValid) |-> !strobe.popOld);
  assert_pop_while_busy_R11: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.popYoung || strobe.popOld) |-> busy);
  assert_quiet_last_cycle_R11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(!(strobe.popYoung || strobe.popOld)));
  assert_no_insert_in_squash_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.popYoung |-> !strobe.pushEn);
endmodule

// File: rtl/rename_hist_buf.sv
module rename_hist_buf
  import rhb_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int SEQ_W  = 8,
  parameter int ARCH_W = 5,
  parameter int PHYS_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              insValid,
  input  logic [SEQ_W-1:0]  insSeq,
  input  logic [ARCH_W-1:0] insArch,
  input  logic [PHYS_W-1:0] insNew,
  input  logic [PHYS_W-1:0] insPrev,
  input  logic              sqValid,
  input  logic [SEQ_W-1:0]  sqSeq,
  input  logic              flushValid,
  input  logic              cmValid,
  input  logic [SEQ_W-1:0]  cmSeq,
  output logic              full,
  output logic              empty,
  output logic              busy,
  output logic              mapWrEn,
  output logic [ARCH_W-1:0] mapWrArch,
  output logic [PHYS_W-1:0] mapWrPhys,
  output logic              freeEn,
  output logic [PHYS_W-1:0] freePhys
);
  rhbStrobe_t       strobe;
  logic [SEQ_W-1:0] youngSeq, oldSeq;

  rhb_ctrl #(.SEQ_W(SEQ_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .insValid(insValid),
    .sqValid(sqValid), .sqSeq(sqSeq), .flushValid(flushValid),
    .cmValid(cmValid), .cmSeq(cmSeq),
    .youngSeq(youngSeq), .oldSeq(oldSeq), .empty(empty), .full(full),
    .strobe(strobe), .busy(busy)
  );

  rhb_store #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .ARCH_W(ARCH_W), .PHYS_W(PHYS_W)) u_store (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .insSeq(insSeq), .insArch(insArch), .insNew(insNew), .insPrev(insPrev),
    .youngSeq(youngSeq), .oldSeq(oldSeq), .empty(empty), .full(full),
    .mapWrEn(mapWrEn), .mapWrArch(mapWrArch), .mapWrPhys(mapWrPhys),
    .freeEn(freeEn), .freePhys(freePhys)
  );

  assert_restore_frees_R3: assert property (@(posedge clk) disable iff (!rstN)
    mapWrEn |-> freeEn);
  assert_empty_not_full_R1: assert property (@(posedge clk) disable iff (!rstN)
    !(empty && full));
endmodule

// File: tb/rename_hist_buf_bench.sv
module rename_hist_buf_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic insValid = 0, sqValid = 0, flushValid = 0, cmValid = 0;
  logic [7:0] insSeq = 0, sqSeq = 0, cmSeq = 0;
  logic [4:0] insArch = 0;
  logic [5:0] insNew = 0, insPrev = 0;
  logic full, empty, busy, mapWrEn, freeEn;
  logic [4:0] mapWrArch;
  logic [5:0] mapWrPhys, freePhys;

  int total = 0, bad = 0;

  logic [7:0] mSeq [DEPTH];
  logic [4:0] mArch [DEPTH];
  logic [5:0] mNew [DEPTH], mPrev [DEPTH];
  int mHead = 0, mCnt = 0;
  logic [7:0] nextSeq = 8'd240;

  always #(CLK_PERIOD/2) clk = ~clk;

  rename_hist_buf u_rename_hist_buf (
    .clk(clk), .rstN(rstN), .insValid(insValid), .insSeq(insSeq), .insArch(insArch),
    .insNew(insNew), .insPrev(insPrev), .sqValid(sqValid), .sqSeq(sqSeq),
    .flushValid(flushValid), .cmValid(cmValid), .cmSeq(cmSeq),
    .full(full), .empty(empty), .busy(busy), .mapWrEn(mapWrEn),
    .mapWrArch(mapWrArch), .mapWrPhys(mapWrPhys), .freeEn(freeEn), .freePhys(freePhys)
  );

  function automatic bit younger(input logic [7:0] a, input logic [7:0] b);
    int d;
    d = int'(a) - int'(b);
    if (d < 0) d += 256;
    return (d > 0) && (d < 128);
  endfunction

  function automatic int yIdx();
    return (mHead + mCnt - 1) % DEPTH;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic collect(input bit sqMode, input bit fl, input logic [7:0] tgt, input string req);
    bit done = 0;
    bit elig;
    chk(busy == 1'b1, "R11 busy after request", int'(busy), 1);
    for (int i = 0; i < 40; i++) begin
      if (!busy) begin done = 1; break; end
      if (sqMode) begin
        elig = (mCnt > 0) && (fl || younger(mSeq[yIdx()], tgt));
        if (elig) begin
          chk(mapWrEn && freeEn, {req, " restore strobes"}, int'({mapWrEn, freeEn}), 3);
          chk(mapWrArch == mArch[yIdx()], {req, " arch"}, int'(mapWrArch), int'(mArch[yIdx()]));
          chk(mapWrPhys == mPrev[yIdx()], {req, " restored phys"}, int'(mapWrPhys), int'(mPrev[yIdx()]));
          chk(freePhys == mNew[yIdx()], {req, " freed new phys"}, int'(freePhys), int'(mNew[yIdx()]));
          mCnt--;
        end else
          chk(!mapWrEn && !freeEn, {req, " quiet end"}, int'({mapWrEn, freeEn}), 0);
      end else begin
        elig = (mCnt > 0) && !younger(mSeq[mHead], tgt);
        if (elig) begin
          chk(freeEn && !mapWrEn, {req, " commit strobes"}, int'({mapWrEn, freeEn}), 1);
          chk(freePhys == mPrev[mHead], {req, " freed prev phys"}, int'(freePhys), int'(mPrev[mHead]));
          mHead = (mHead + 1) % DEPTH;
          mCnt--;
        end else
          chk(!mapWrEn && !freeEn, {req, " quiet end"}, int'({mapWrEn, freeEn}), 0);
      end
      @(negedge clk);
    end
    chk(done, "R11 walk ends", int'(done), 1);
    if (sqMode) elig = (mCnt > 0) && (fl || younger(mSeq[yIdx()], tgt));
    else        elig = (mCnt > 0) && !younger(mSeq[mHead], tgt);
    chk(!elig, {req, " nothing left eligible"}, int'(elig), 0);
  endtask

  task automatic op(input bit ins, input bit sq, input bit fl, input bit cm,
                    input logic [7:0] seq, input logic [4:0] ar, input logic [5:0] nw,
                    input logic [5:0] pv, input logic [7:0] sTgt, input logic [7:0] cTgt,
                    input string req);
    @(negedge clk);
    chk(full == (mCnt == DEPTH), "R2 full flag", int'(full), int'(mCnt == DEPTH));
    chk(empty == (mCnt == 0), "R2 empty flag", int'(empty), int'(mCnt == 0));
    insValid = ins; insSeq = seq; insArch = ar; insNew = nw; insPrev = pv;
    sqValid = sq; sqSeq = sTgt; flushValid = fl; cmValid = cm; cmSeq = cTgt;
    @(negedge clk);
    insValid = 0; sqValid = 0; flushValid = 0; cmValid = 0;
    if (ins && !sq && !fl && mCnt < DEPTH) begin
      mSeq[(mHead + mCnt) % DEPTH] = seq; mArch[(mHead + mCnt) % DEPTH] = ar;
      mNew[(mHead + mCnt) % DEPTH] = nw;  mPrev[(mHead + mCnt) % DEPTH] = pv;
      mCnt++;
    end
    if (sq || fl)  collect(1'b1, fl, sTgt, req);
    else if (cm)   collect(1'b0, 1'b0, cTgt, req);
  endtask

  task automatic push(input logic [7:0] seq);
    op(1, 0, 0, 0, seq, 5'($urandom), 6'($urandom), 6'($urandom), 0, 0, "R2 insert");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] a;
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(empty && !full && !busy && !mapWrEn && !freeEn, "R1 reset state",
        int'({empty, full, busy, mapWrEn, freeEn}), 16);

    // R2 multi-destination and R3 squash of the younger instruction
    push(8'd240); push(8'd241); push(8'd241);
    op(0, 1, 0, 0, 0, 0, 0, 0, 8'd240, 0, "R3 squash younger");
    // R7 commit older than oldest
    op(0, 0, 0, 1, 0, 0, 0, 0, 0, 8'd239, "R7 commit older");
    // R6 commit
    op(0, 0, 0, 1, 0, 0, 0, 0, 0, 8'd240, "R6 commit");
    // R7 commit on empty, R4 squash on empty
    op(0, 0, 0, 1, 0, 0, 0, 0, 0, 8'd250, "R7 commit empty");
    op(0, 1, 0, 0, 0, 0, 0, 0, 8'd200, 0, "R4 squash empty");

    // R2 full and overflow, R9 across wrap, R5 flush
    for (int i = 0; i < DEPTH; i++) push(8'(8'd252 + i));
    op(1, 0, 0, 0, 8'd99, 1, 1, 1, 0, 0, "R2 insert while full");
    op(0, 0, 0, 1, 0, 0, 0, 0, 0, 8'd1, "R9 commit across wrap");
    op(0, 1, 0, 0, 0, 0, 0, 0, 8'd2, 0, "R9 squash across wrap");
    op(0, 0, 1, 0, 0, 0, 0, 0, 0, 0, "R5 flush");

    // R8 commit and squash together; R2 insert ignored during squash request
    nextSeq = 8'd10;
    for (int i = 0; i < 4; i++) push(8'(nextSeq + i));
    op(1, 1, 0, 1, 8'd50, 3, 3, 3, 8'd11, 8'd13, "R8 squash beats commit");
    // R10 flush beats squash
    op(0, 1, 1, 0, 0, 0, 0, 0, 8'd10, 0, "R10 flush wins");

    // R8 squash aborts a commit walk
    a = 8'd20;
    for (int i = 0; i < 4; i++) push(8'(a + i));
    @(negedge clk);
    cmValid = 1; cmSeq = 8'(a + 2);
    @(negedge clk);
    cmValid = 0;
    chk(freeEn && freePhys == mPrev[mHead], "R6 first commit pop", int'(freePhys), int'(mPrev[mHead]));
    mHead = (mHead + 1) % DEPTH; mCnt--;
    @(negedge clk);
    sqValid = 1; sqSeq = 8'(a + 2);
    #1;
    chk(!freeEn, "R8 commit cancelled by squash", int'(freeEn), 0);
    @(negedge clk);
    sqValid = 0;
    collect(1'b1, 1'b0, 8'(a + 2), "R8 squash after abort");
    op(0, 0, 1, 0, 0, 0, 0, 0, 0, 0, "R5 flush remainder");

    // random mix
    nextSeq = 8'd200;
    for (int it = 0; it < 500; it++) begin
      int r;
      r = int'($urandom % 10);
      if (mCnt > 0 && (int'(nextSeq) - int'(mSeq[mHead]) + 256) % 256 > 60)
        op(0, 0, 0, 1, 0, 0, 0, 0, 0, nextSeq, "R6 random drain");
      else if (r < 5 && mCnt < DEPTH) begin
        if (!(mCnt > 0 && ($urandom % 3) == 0)) nextSeq = nextSeq + 1'b1;
        push(nextSeq);
      end else if (r < 7)
        op(0, 1, 0, 0, 0, 0, 0, 0, 8'(nextSeq - 8'($urandom % (mCnt + 2))), 0, "R3 random squash");
      else if (r == 7 && ($urandom % 4) == 0)
        op(0, 0, 1, 0, 0, 0, 0, 0, 0, 0, "R5 random flush");
      else
        op(0, 0, 0, 1, 0, 0, 0, 0, 0,
           (mCnt > 0) ? 8'(mSeq[mHead] - 1 + 8'($urandom % (mCnt + 2))) : 8'($urandom),
           "R6 random commit");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule